// File: doc/BRIEF.md
# Alarm Status Change Latch Register

This block turns the live alarm and synchronisation status of a T1/E1 receive framer into sticky latch bits that a host processor can read. A mode input chooses which set is active. In T1 mode the latched events are a severely errored frame, AIS, loss of signal and each increment of the CRC-6 error counter. In E1 mode the latched events are remote CRC-4/RAI, receive slip, Y-bit, auxiliary pattern, RAI, AIS, AIS16 and loss of signal. Each latch bit has its own trigger. Some bits set only on a 0-to-1 move of their status. Others set on any change in either direction. The CRC bit sets on a pulse from the error counter.

Each status input is compared with its own value registered one clock earlier. The previous-value registers track both sets in both modes, so a change of mode creates no event by itself. Events that belong to the set not selected are dropped. A host read strobe at the latch register address returns the latch field of the active mode. A read at that address, or at the interrupt status address, clears every latch bit at the next clock edge. If an event and a clearing read land in the same cycle, the event wins.

Top module: `alarmLatchReg`

## Requirements
- R1: In T1 mode (`e1Mode`=0), `t1Status[2]` (severely errored frame), `t1Status[1]` (AIS) and `t1Status[0]` (loss of signal) set latch bits 3, 2 and 0 of the read word. They set on a 0-to-1 change only, and never on a 1-to-0 change.
- R2: In T1 mode, a cycle with `crcInc`=1 sets latch bit 1 of the read word.
- R3: In E1 mode (`e1Mode`=1), `e1Status[7]` (remote CRC/RAI) and `e1Status[4]` (auxiliary pattern) set read-word bits 14 and 11. They set on a 0-to-1 change only.
- R4: In E1 mode, `e1Status[6]` (slip), `[5]` (Y-bit), `[3]` (RAI), `[2]` (AIS), `[1]` (AIS16) and `[0]` (loss of signal) set read-word bits 13, 12, 10, 9, 8 and 7. They set on a change in either direction. In general, `e1Status[i]` maps to read-word bit 7+i.
- R5: A latch bit stays set after its status returns to its old value, until a clearing read.
- R6: `rdStrobe`=1 with `rdAddr` equal to LATCH_ADDR (default 0x24) or IRQ_ADDR (default 0x34) clears all latch bits of both modes at the next clock edge. The read in that cycle returns the pre-clear values. A strobe at any other address clears nothing.
- R7: When a set event and a clearing read occur in the same cycle, the event's latch bit is 1 after that edge.
- R8: Reset (`rstN`=0, asynchronous) clears all latch bits and all previous-status registers to 0.
- R9: `rdData` is 0 unless `rdStrobe`=1 and `rdAddr`=LATCH_ADDR. A read at IRQ_ADDR returns 0. Bits outside the active mode's field (T1: 3..0, E1: 14..7) always read 0.
- R10: Events from the set that is not selected by `e1Mode` set no latch bit, and a change of `e1Mode` alone sets no latch bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| e1Mode | input | 1 | 0 selects the T1 latch set, 1 selects the E1 latch set |
| t1Status | input | 3 | T1 live status: [2] severely errored frame, [1] AIS, [0] loss of signal |
| crcInc | input | 1 | CRC-6 error counter increment pulse |
| e1Status | input | 8 | E1 live status: [7] remote CRC/RAI, [6] slip, [5] Y-bit, [4] auxiliary pattern, [3] RAI, [2] AIS, [1] AIS16, [0] loss of signal |
| rdStrobe | input | 1 | Host read strobe |
| rdAddr | input | ADDR_W | Host read address |
| rdData | output | 16 | Read word, valid while the latch address is strobed |

## Verification
The hardest situation to reach from the ports is a clearing read that lands in the same cycle as a fresh status edge. The clear and the set then compete for one bit. The stimulus table places a status step, a CRC pulse and an any-change fall in the very cycle of a latch-address read. The following read then shows the bit still held. The table also walks through mode changes while the inactive set is toggling. The read in the new mode then proves that nothing leaked across and that the mode switch itself produced no edge.

// File: rtl/alarmLatchPkg.sv
package alarmLatchPkg;
  localparam int T1_LATCH_W = 4;
  localparam int E1_LATCH_W = 8;
  localparam int RD_W       = 16;
  localparam int E1_LSB     = 7;
  // 1 = set on any change, 0 = set on rising edge only (e1Status bit order)
  localparam logic [E1_LATCH_W-1:0] E1_ANY_EDGE = 8'b0110_1111;

  typedef struct packed {
    logic clrAll;   // clearing read this cycle
    logic rdLatch;  // latch register selected for read data
  } latchCtl_t;
endpackage

// File: rtl/alarmEdgeDet.sv
module alarmEdgeDet #(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] ANY_MASK = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] evt
);
  logic [WIDTH-1:0] prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= din;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    if (ANY_MASK[i]) begin : gAny
      assign evt[i] = din[i] ^ prevQ[i];
    end else begin : gRise
      assign evt[i] = din[i] & ~prevQ[i];
    end
  end
endmodule

// File: rtl/alarmLatchCtl.sv
module alarmLatchCtl
  import alarmLatchPkg::*;
#(
  parameter int                ADDR_W     = 6,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 6'h24,
  parameter logic [ADDR_W-1:0] IRQ_ADDR   = 6'h34
) (
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output latchCtl_t         ctl
);
  logic latchHit;
  logic irqHit;

  always_comb begin
    latchHit    = rdStrobe && (rdAddr == LATCH_ADDR);
    irqHit      = rdStrobe && (rdAddr == IRQ_ADDR);
    ctl.rdLatch = latchHit;
    ctl.clrAll  = latchHit || irqHit;
  end
endmodule

// File: rtl/alarmLatchDp.sv
module alarmLatchDp
  import alarmLatchPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  e1Mode,
  input  logic [2:0]            t1Status,
  input  logic                  crcInc,
  input  logic [E1_LATCH_W-1:0] e1Status,
  input  latchCtl_t             ctl,
  output logic [RD_W-1:0]       rdData,
  output logic [T1_LATCH_W-1:0] latchT1Q,
  output logic [E1_LATCH_W-1:0] latchE1Q
);
  logic [2:0]            t1Edge;
  logic [E1_LATCH_W-1:0] e1Evt;
  logic [T1_LATCH_W-1:0] t1Set;
  logic [E1_LATCH_W-1:0] e1Set;

  alarmEdgeDet #(.WIDTH(3), .ANY_MASK(3'b000)) uT1Edge (
    .clk(clk), .rstN(rstN), .din(t1Status), .evt(t1Edge)
  );

  alarmEdgeDet #(.WIDTH(E1_LATCH_W), .ANY_MASK(E1_ANY_EDGE)) uE1Edge (
    .clk(clk), .rstN(rstN), .din(e1Status), .evt(e1Evt)
  );

  always_comb begin
    t1Set = {t1Edge[2], t1Edge[1], crcInc, t1Edge[0]} & {T1_LATCH_W{!e1Mode}};
    e1Set = e1Evt & {E1_LATCH_W{e1Mode}};
  end

  // set has priority over the clearing read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchT1Q <= '0;
      latchE1Q <= '0;
    end else begin
      latchT1Q <= (latchT1Q & {T1_LATCH_W{!ctl.clrAll}}) | t1Set;
      latchE1Q <= (latchE1Q & {E1_LATCH_W{!ctl.clrAll}}) | e1Set;
    end
  end

  always_comb begin
    rdData = '0;
    if (ctl.rdLatch) begin
      if (e1Mode) rdData[E1_LSB +: E1_LATCH_W] = latchE1Q;
      else        rdData[T1_LATCH_W-1:0]       = latchT1Q;
    end
  end
endmodule

// File: rtl/alarmLatchReg.sv
module alarmLatchReg
  import alarmLatchPkg::*;
#(
  parameter int                ADDR_W     = 6,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 6'h24,
  parameter logic [ADDR_W-1:0] IRQ_ADDR   = 6'h34
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              e1Mode,
  input  logic [2:0]        t1Status,
  input  logic              crcInc,
  input  logic [7:0]        e1Status,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [15:0]       rdData
);
  latchCtl_t             ctl;
  logic [T1_LATCH_W-1:0] latchT1Q;
  logic [E1_LATCH_W-1:0] latchE1Q;

  alarmLatchCtl #(
    .ADDR_W(ADDR_W), .LATCH_ADDR(LATCH_ADDR), .IRQ_ADDR(IRQ_ADDR)
  ) uCtl (
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .ctl(ctl)
  );

  alarmLatchDp uDp (
    .clk(clk), .rstN(rstN), .e1Mode(e1Mode), .t1Status(t1Status),
    .crcInc(crcInc), .e1Status(e1Status), .ctl(ctl), .rdData(rdData),
    .latchT1Q(latchT1Q), .latchE1Q(latchE1Q)
  );
endmodule

// File: rtl/alarmLatchReg_chk.sv
module alarmLatchReg_chk #(
  parameter int                ADDR_W     = 6,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 6'h24,
  parameter logic [ADDR_W-1:0] IRQ_ADDR   = 6'h34
) (
  input logic              clk,
  input logic              rstN,
  input logic              e1Mode,
  input logic [2:0]        t1Status,
  input logic              crcInc,
  input logic [7:0]        e1Status,
  input logic              rdStrobe,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [3:0]        latchT1Q,
  input logic [7:0]        latchE1Q
);
  logic clrHit;
  assign clrHit = rdStrobe && (rdAddr == LATCH_ADDR || rdAddr == IRQ_ADDR);

  assert_reset_clear_R8: assert property (@(posedge clk)
    !rstN |=> (latchT1Q == 4'd0 && latchE1Q == 8'd0));

  assert_t1_sef_rise_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!e1Mode && $past(rstN) && t1Status[2] && !$past(t1Status[2])) |=> latchT1Q[3]);

  assert_crc_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!e1Mode && crcInc) |=> latchT1Q[1]);

  assert_e1_rcr_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    (e1Mode && $past(rstN) && e1Status[7] && !$past(e1Status[7])) |=> latchE1Q[7]);

  assert_e1_slip_change_R4: assert property (@(posedge clk) disable iff (!rstN)
    (e1Mode && $past(rstN) && (e1Status[6] != $past(e1Status[6]))) |=> latchE1Q[6]);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> (((latchT1Q & $past(latchT1Q)) == $past(latchT1Q)) &&
                   ((latchE1Q & $past(latchE1Q)) == $past(latchE1Q))));

  assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clrHit && $past(rstN) && !crcInc && $stable(t1Status) && $stable(e1Status))
      |=> (latchT1Q == 4'd0 && latchE1Q == 8'd0));
endmodule

bind alarmLatchReg alarmLatchReg_chk #(
  .ADDR_W(ADDR_W), .LATCH_ADDR(LATCH_ADDR), .IRQ_ADDR(IRQ_ADDR)
) uChk (
  .clk(clk), .rstN(rstN), .e1Mode(e1Mode), .t1Status(t1Status),
  .crcInc(crcInc), .e1Status(e1Status), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
  .latchT1Q(latchT1Q), .latchE1Q(latchE1Q)
);

// File: tb/alarmLatchReg_test.sv
module alarmLatchReg_test;
  localparam logic [5:0] A_LAT = 6'h24;
  localparam logic [5:0] A_IRQ = 6'h34;
  localparam logic [5:0] A_OTH = 6'h10;
  localparam int NV = 28;

  typedef struct packed {
    logic       e1;
    logic [2:0] t1;
    logic       crc;
    logic [7:0] e1s;
    logic       rd;
    logic [5:0] addr;
    logic [15:0] exp;
  } vec_t;

  // exp = rdData before the edge that applies this row
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'b000, 1'b0, 8'h00, 1'b1, A_LAT, 16'h0000}, // 0  R8 reset state
    '{1'b0, 3'b100, 1'b0, 8'h00, 1'b0, A_LAT, 16'h0000}, // 1  R1 SEF rise
    '{1'b0, 3'b100, 1'b0, 8'h00, 1'b1, A_OTH, 16'h0000}, // 2  R9 other addr
    '{1'b0, 3'b000, 1'b0, 8'h00, 1'b1, A_LAT, 16'h0008}, // 3  R1 R6 read+fall
    '{1'b0, 3'b000, 1'b0, 8'h00, 1'b1, A_LAT, 16'h0000}, // 4  R1 fall no set
    '{1'b0, 3'b011, 1'b1, 8'h00, 1'b0, A_LAT, 16'h0000}, // 5  R1 R2 events
    '{1'b0, 3'b011, 1'b0, 8'h00, 1'b0, A_LAT, 16'h0000}, // 6  R9 no strobe
    '{1'b0, 3'b000, 1'b0, 8'h00, 1'b0, A_LAT, 16'h0000}, // 7  R5 status falls
    '{1'b0, 3'b000, 1'b0, 8'h00, 1'b1, A_IRQ, 16'h0000}, // 8  R9 irq read data 0
    '{1'b0, 3'b000, 1'b0, 8'h00, 1'b1, A_LAT, 16'h0000}, // 9  R6 irq cleared
    '{1'b0, 3'b100, 1'b0, 8'h00, 1'b1, A_LAT, 16'h0000}, // 10 R7 rise with read
    '{1'b0, 3'b100, 1'b0, 8'h00, 1'b1, A_LAT, 16'h0008}, // 11 R7 set won
    '{1'b0, 3'b100, 1'b1, 8'h00, 1'b1, A_LAT, 16'h0000}, // 12 R7 crc with read
    '{1'b0, 3'b100, 1'b0, 8'h00, 1'b1, A_LAT, 16'h0002}, // 13 R2 R7 crc held
    '{1'b0, 3'b100, 1'b0, 8'hFF, 1'b0, A_LAT, 16'h0000}, // 14 R10 E1 moves in T1
    '{1'b1, 3'b000, 1'b0, 8'hFF, 1'b1, A_LAT, 16'h0000}, // 15 R10 E1 empty
    '{1'b1, 3'b000, 1'b0, 8'hFF, 1'b1, A_LAT, 16'h0000}, // 16 R10 no switch event
    '{1'b1, 3'b000, 1'b0, 8'h00, 1'b0, A_LAT, 16'h0000}, // 17 R3 R4 all fall
    '{1'b1, 3'b000, 1'b0, 8'h00, 1'b1, A_LAT, 16'h3780}, // 18 R3 R4 any-change only
    '{1'b1, 3'b111, 1'b1, 8'h80, 1'b0, A_LAT, 16'h0000}, // 19 R3 rcr rise, T1 ignored
    '{1'b1, 3'b111, 1'b0, 8'h80, 1'b1, A_LAT, 16'h4000}, // 20 R3 bit 14
    '{1'b1, 3'b111, 1'b0, 8'h10, 1'b0, A_LAT, 16'h0000}, // 21 R3 aux rise
    '{1'b0, 3'b111, 1'b0, 8'h10, 1'b1, A_LAT, 16'h0000}, // 22 R10 T1 untouched
    '{1'b1, 3'b111, 1'b0, 8'h10, 1'b1, A_LAT, 16'h0000}, // 23 R6 E1 cleared too
    '{1'b1, 3'b111, 1'b0, 8'h01, 1'b0, A_LAT, 16'h0000}, // 24 R4 los rise
    '{1'b1, 3'b111, 1'b0, 8'h00, 1'b1, A_LAT, 16'h0080}, // 25 R7 los fall with read
    '{1'b1, 3'b111, 1'b0, 8'h00, 1'b1, A_LAT, 16'h0080}, // 26 R7 set won in E1
    '{1'b1, 3'b111, 1'b0, 8'h00, 1'b1, A_LAT, 16'h0000}  // 27 R6 cleared
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        e1Mode = 1'b0;
  logic [2:0]  t1Status = 3'b000;
  logic        crcInc = 1'b0;
  logic [7:0]  e1Status = 8'h00;
  logic        rdStrobe = 1'b0;
  logic [5:0]  rdAddr = 6'h00;
  logic [15:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  alarmLatchReg uut (
    .clk(clk), .rstN(rstN), .e1Mode(e1Mode), .t1Status(t1Status),
    .crcInc(crcInc), .e1Status(e1Status), .rdStrobe(rdStrobe),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: rdData=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      e1Mode   = VECS[i].e1;
      t1Status = VECS[i].t1;
      crcInc   = VECS[i].crc;
      e1Status = VECS[i].e1s;
      rdStrobe = VECS[i].rd;
      rdAddr   = VECS[i].addr;
      #1;
      check($sformatf("vector %0d", i), rdData, VECS[i].exp);
    end

    // directed: R8 asynchronous reset wipes a set latch
    @(negedge clk);
    e1Mode = 1'b0; t1Status = 3'b000; crcInc = 1'b0; rdStrobe = 1'b0;
    @(negedge clk);
    t1Status = 3'b100;
    @(negedge clk);
    rdStrobe = 1'b1; rdAddr = A_OTH; #1;
    check("R9 other address while latched", rdData, 16'h0000);
    rdAddr = A_LAT; #1;
    check("R1 SEF latched before reset", rdData, 16'h0008);
    rstN = 1'b0; #1;
    check("R8 reset clears latch", rdData, 16'h0000);
    rdStrobe = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    // R8: previous-status register reset to 0, so held SEF reads as a new rise
    @(negedge clk);
    rdStrobe = 1'b1; rdAddr = A_LAT; #1;
    check("R8 prev status reset to 0", rdData, 16'h0008);
    @(negedge clk);
    rdStrobe = 1'b0; crcInc = 1'b1;
    @(negedge clk);
    crcInc = 1'b0; rdStrobe = 1'b1; #1;
    check("R2 crc pulse after reset", rdData, 16'h0002);
    @(negedge clk);
    rdStrobe = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule